// File: doc/BRIEF.md
# UART Bit-Timing Generator

This block derives the two timing strobes a UART needs from a single system clock. A 32-bit configuration word sets two values. The low field is a clock prescaler N: the block emits one sample strobe every N+1 clocks. The upper field is an oversampling count S: every S+1 sample strobes, one bit strobe marks the end of a bit period. The serial rate is therefore clk / ((N+1) * (S+1)). With a 150 MHz clock, the word 0x0014003D comes out at roughly 115.2 kbaud. The word 0x00240000 runs at 150 MHz / 37, about 4 Mbaud.

A transmitter shifts on the bit strobe. A receiver uses the running sample phase and the mid-bit strobe to place its decision point near the centre of each bit. The oversampling ratio can be set anywhere from 16 to 64 samples per bit, so a coarse prescaler and a fine sample count can be traded against each other for each rate. Any write of the configuration word restarts both counters from zero. An enable input holds both counters at zero while it is low.

Top module: `uart_baud_gen`

## Requirements
- R1: After reset the configuration holds N=61 and S=20 (word 0x0014003D), the sample phase is 0 and all three strobes are low. The first bit strobe after enable rises in enabled cycle 1302.
- R2: While enabled and not being written, `sample_tick` is high for exactly one clock in every N+1 clocks. N is `cfg_data[15:0]`, which allows 0 to 65535.
- R3: `bit_tick` is high only together with the `sample_tick` that ends phase S. S is taken from `cfg_data[21:16]`, so one bit strobe occurs every S+1 sample strobes.
- R4: The interval between bit strobes is (N+1)*(S+1) clocks. For example, 0x00240000 gives 37 clocks and 0x0014003D gives 1302 clocks.
- R5: In a clock with `cfg_we` high, no strobe is produced. From the next clock both counters start at zero, so the first sample strobe falls in clock N+1 and the first bit strobe in clock (N+1)*(S+1) after the write.
- R6: `sample_phase` counts sample strobes from 0 to S. It changes only on a sample strobe and returns to 0 after the bit strobe.
- R7: `mid_bit` is high together with the `sample_tick` on which `sample_phase` equals floor(S/2). It is low otherwise.
- R8: A written sample count below 15 is raised to 15. Bits [31:22] of the word are ignored.
- R9: While `enable` is low, no strobe is produced and the sample phase reads 0. After `enable` rises, timing restarts from zero: the first bit strobe comes in enabled cycle (N+1)*(S+1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the prescaler |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run control; low holds both counters at zero |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_data | input | 32 | Configuration word: [15:0] prescaler N, [21:16] sample count S |
| sample_tick | output | 1 | One-clock sample strobe |
| bit_tick | output | 1 | One-clock bit-period strobe |
| mid_bit | output | 1 | Sample strobe at the middle phase of the bit |
| sample_phase | output | 6 | Index of the current sample within the bit, 0 to S |

## Verification
The bench focuses on four behaviours: the exact clock at which the first bit strobe follows a write or the rise of enable, the raising of a too-small sample count, the masking of the unused upper bits, and a write that lands in the middle of a bit. A design that let the old count run on after a write would deliver a short first bit. A design that failed to raise the sample count would give a 64-clock check a shorter period. A design that decoded bits [31:22] would give the masking check a different period. The bench also compares every strobe and the phase on every clock against a behavioural model. An off-by-one in either wrap compare, or a mid-bit decoded from the wrong phase, therefore shows up on the first bit.

// File: rtl/baud_pkg.sv
`timescale 1ns/1ps
package baud_pkg;
  localparam int DIV_W   = 32;
  localparam int PRE_W   = 16;
  localparam int SMP_W   = 6;
  localparam int SMP_LSB = 16;
  localparam int SMP_MIN = 15;
  localparam logic [DIV_W-1:0] DIV_RESET = 32'h0014_003D;

  typedef struct packed {
    logic [SMP_W-1:0] samples;
    logic [PRE_W-1:0] prescale;
  } baud_cfg_t;

  // Prescaler field of a configuration word.
  function automatic logic [PRE_W-1:0] cfg_prescale(input logic [DIV_W-1:0] w);
    return w[PRE_W-1:0];
  endfunction

  // Sample-count field, raised to the smallest supported ratio.
  function automatic logic [SMP_W-1:0] cfg_samples(input logic [DIV_W-1:0] w);
    logic [SMP_W-1:0] s;
    s = w[SMP_LSB +: SMP_W];
    return (s < SMP_W'(SMP_MIN)) ? SMP_W'(SMP_MIN) : s;
  endfunction

  function automatic baud_cfg_t cfg_decode(input logic [DIV_W-1:0] w);
    baud_cfg_t c;
    c.prescale = cfg_prescale(w);
    c.samples  = cfg_samples(w);
    return c;
  endfunction
endpackage

// File: rtl/baud_cfg_reg.sv
`timescale 1ns/1ps
module baud_cfg_reg
  import baud_pkg::*;
#(
  parameter logic [DIV_W-1:0] RESET_WORD = DIV_RESET
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [DIV_W-1:0] wdata,
  output logic [PRE_W-1:0] pre_limit,
  output logic [SMP_W-1:0] smp_limit,
  output logic             restart
);
  localparam int USED_W = SMP_LSB + SMP_W;
  localparam baud_cfg_t RESET_CFG = cfg_decode(RESET_WORD);

  baud_cfg_t cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  cfg_q <= RESET_CFG;
    else if (we) cfg_q <= cfg_decode(wdata);
  end

  generate
    if (DIV_W > USED_W) begin : g_spare
      logic unused_hi;
      assign unused_hi = ^wdata[DIV_W-1:USED_W];
    end
  endgenerate

  assign pre_limit = cfg_q.prescale;
  assign smp_limit = cfg_q.samples;
  assign restart   = we;
endmodule

// File: rtl/baud_prescaler.sv
`timescale 1ns/1ps
module baud_prescaler #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         restart,
  input  logic [W-1:0] limit,
  output logic         tick
);
  logic [W-1:0] cnt_q;
  logic         at_end;

  assign at_end = (cnt_q == limit);
  assign tick   = run & ~restart & at_end;

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (restart || !run)  cnt_q <= '0;
    else if (at_end)           cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/baud_phase_ctr.sv
`timescale 1ns/1ps
module baud_phase_ctr #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         restart,
  input  logic         step,
  input  logic [W-1:0] limit,
  output logic [W-1:0] phase,
  output logic         wrap,
  output logic         mid
);
  logic [W-1:0] ph_q;
  logic [W-1:0] mid_point;

  assign mid_point = limit >> 1;
  assign phase     = ph_q;
  assign wrap      = step & (ph_q == limit);
  assign mid       = step & (ph_q == mid_point);

  always_ff @(posedge clk) begin
    if (!rst_n)                ph_q <= '0;
    else if (restart || !run)  ph_q <= '0;
    else if (wrap)             ph_q <= '0;
    else if (step)             ph_q <= ph_q + 1'b1;
  end
endmodule

// File: rtl/uart_baud_gen.sv
`timescale 1ns/1ps
module uart_baud_gen
  import baud_pkg::*;
#(
  parameter logic [31:0] RESET_WORD = DIV_RESET
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic        cfg_we,
  input  logic [31:0] cfg_data,
  output logic        sample_tick,
  output logic        bit_tick,
  output logic        mid_bit,
  output logic [5:0]  sample_phase
);
  logic [PRE_W-1:0] pre_limit;
  logic [SMP_W-1:0] smp_limit;
  logic             restart;
  logic             smp_step;

  baud_cfg_reg #(.RESET_WORD(RESET_WORD)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (cfg_we),
    .wdata     (cfg_data),
    .pre_limit (pre_limit),
    .smp_limit (smp_limit),
    .restart   (restart)
  );

  baud_prescaler #(.W(PRE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (enable),
    .restart (restart),
    .limit   (pre_limit),
    .tick    (smp_step)
  );

  baud_phase_ctr #(.W(SMP_W)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (enable),
    .restart (restart),
    .step    (smp_step),
    .limit   (smp_limit),
    .phase   (sample_phase),
    .wrap    (bit_tick),
    .mid     (mid_bit)
  );

  assign sample_tick = smp_step;
endmodule

// File: rtl/baud_gen_checker.sv
`timescale 1ns/1ps
module baud_gen_checker #(
  parameter int W = 6
) (
  input logic         clk,
  input logic         rst_n,
  input logic         enable,
  input logic         cfg_we,
  input logic         sample_tick,
  input logic         bit_tick,
  input logic         mid_bit,
  input logic [W-1:0] sample_phase,
  input logic [W-1:0] smp_limit
);
  // R3
  bit_on_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> sample_tick);

  // R7
  mid_on_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mid_bit |-> sample_tick);

  // R5
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> !sample_tick);

  // R5
  write_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (sample_phase == '0));

  // R6
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick && !bit_tick) |=> (sample_phase == $past(sample_phase) + 1'b1));

  // R6
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !cfg_we && !sample_tick) |=> $stable(sample_phase));

  // R6
  phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> (sample_phase == '0));

  // R6
  phase_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_phase <= smp_limit);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (!sample_tick && !bit_tick && !mid_bit));

  // R9
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (sample_phase == '0));
endmodule

bind uart_baud_gen baud_gen_checker #(.W(6)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .enable       (enable),
  .cfg_we       (cfg_we),
  .sample_tick  (sample_tick),
  .bit_tick     (bit_tick),
  .mid_bit      (mid_bit),
  .sample_phase (sample_phase),
  .smp_limit    (smp_limit)
);

// File: tb/uart_baud_gen_bench.sv
`timescale 1ns/1ps
module uart_baud_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_data = '0;
  logic        sample_tick, bit_tick, mid_bit;
  logic [5:0]  sample_phase;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 1'b0;

  // behavioural reference state
  int m_n = 61, m_s = 20, m_pre = 0, m_smp = 0;

  uart_baud_gen u_uart_baud_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_we(cfg_we),
    .cfg_data(cfg_data), .sample_tick(sample_tick), .bit_tick(bit_tick),
    .mid_bit(mid_bit), .sample_phase(sample_phase)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  function automatic int word_n(input logic [31:0] w);
    return int'(w & 32'hFFFF);
  endfunction

  function automatic int word_s(input logic [31:0] w);
    int s;
    s = int'((w >> 16) & 32'h3F);
    return (s < 15) ? 15 : s;
  endfunction

  // reference model advances on each rising edge
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_n = 61; m_s = 20; m_pre = 0; m_smp = 0;
    end else if (cfg_we) begin
      m_n = word_n(cfg_data); m_s = word_s(cfg_data); m_pre = 0; m_smp = 0;
    end else if (!enable) begin
      m_pre = 0; m_smp = 0;
    end else if (m_pre == m_n) begin
      m_pre = 0;
      m_smp = (m_smp == m_s) ? 0 : m_smp + 1;
    end else begin
      m_pre = m_pre + 1;
    end
    if (cyc > 150000) begin
      chk(1'b0, "watchdog", cyc, 150000);
      finish_run();
    end
  end

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    bit e_st, e_bt, e_mid;
    #2;
    e_st  = rst_n && enable && !cfg_we && (m_pre == m_n);
    e_bt  = e_st && (m_smp == m_s);
    e_mid = e_st && (m_smp == m_s / 2);
    chk(sample_tick == e_st, "R2 sample_tick", int'(sample_tick), int'(e_st));
    chk(bit_tick == e_bt, "R3 bit_tick", int'(bit_tick), int'(e_bt));
    chk(mid_bit == e_mid, "R7 mid_bit", int'(mid_bit), int'(e_mid));
    chk(int'(sample_phase) == m_smp, "R6 sample_phase", int'(sample_phase), m_smp);
  end

  task automatic apply_div(input logic [31:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_data = w;
    @(negedge clk);
    cfg_we = 1'b0; cfg_data = 32'hA5A5_A5A5;
  endtask

  // called at a falling edge; that cycle counts as cycle 1
  task automatic measure(input int ncyc, input int period, input int mid_first,
                         input string tag);
    int first = -1, last = -1, bad = 0, nbits = 0, fmid = -1;
    for (int k = 1; k <= ncyc; k++) begin
      #2;
      if (mid_bit && fmid < 0) fmid = k;
      if (bit_tick) begin
        if (first < 0) first = k;
        else if (k - last != period) bad++;
        last = k;
        nbits++;
      end
      @(negedge clk);
    end
    chk(first == period, {tag, " first bit strobe"}, first, period);
    chk(bad == 0, {tag, " bit interval"}, bad, 0);
    chk(nbits == ncyc / period, {tag, " bit count"}, nbits, ncyc / period);
    chk(fmid == mid_first, {tag, " R7 first mid strobe"}, fmid, mid_first);
  endtask

  initial begin
    int quiet;
    repeat (3) @(negedge clk);
    #2;
    // R1 reset state
    chk(sample_phase == 6'd0, "R1 reset phase", int'(sample_phase), 0);
    chk(!sample_tick && !bit_tick && !mid_bit, "R1 reset strobes",
        int'(sample_tick) + int'(bit_tick) + int'(mid_bit), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    enable = 1'b1;
    measure(2700, 1302, 682, "R1 R4 default word");

    apply_div(32'h0024_0000);
    measure(370, 37, 19, "R4 R5 fastest word");

    apply_div(32'h0005_0003);
    measure(640, 64, 32, "R8 raised sample count");

    apply_div(32'hFFE0_0004);
    measure(660, 165, 85, "R8 upper bits ignored");

    // R9 idle: nothing moves while disabled
    @(negedge clk);
    enable = 1'b0;
    quiet = 0;
    for (int k = 0; k < 60; k++) begin
      #2;
      if (sample_tick || bit_tick || mid_bit || sample_phase != 6'd0) quiet++;
      @(negedge clk);
    end
    chk(quiet == 0, "R9 disabled activity", quiet, 0);
    enable = 1'b1;
    measure(660, 165, 85, "R9 resume");

    // R5 write landing mid-bit
    repeat (40) @(negedge clk);
    apply_div(32'h0010_0002);
    measure(510, 51, 27, "R5 mid-bit rewrite");

    // R2 prescaler at N=0 keeps sample strobe high every clock
    apply_div(32'h003F_0000);
    quiet = 0;
    for (int k = 0; k < 64; k++) begin
      #2;
      if (!sample_tick) quiet++;
      @(negedge clk);
    end
    chk(quiet == 0, "R2 N=0 every clock", quiet, 0);

    finish_run();
  end
endmodule